// File: doc/BRIEF.md
# APB4 Control/Status Register Port

This block is an APB4 completer placed in front of a bank of four data-bus-wide registers: two general control words, one status word sampled from a design input, and one trigger word that the bus can only write. A bus master reaches the registers through byte addresses. The block runs the setup/access handshake with no wait states. It returns read data during the access cycle. Writes take effect at the clock edge that ends the access.

Two independent parameters decide which accesses draw an error response. One covers addresses that match no register. The other covers accesses in the wrong direction for the register. A third parameter selects APB3 behaviour. In that mode the error output stays tied low, every write updates all byte lanes, and the bad accesses are simply ignored. All bus signals are separate ports.

Top module: `apb_csr_port`

## Requirements
- R1: PADDR is a byte address. Bits [3:2] select the register and bits [1:0] play no part. Offset 0x0 is control word A (read/write). 0x4 is the status word (read-only, returns `status_in`). 0x8 is the trigger word (write-only). 0xC is control word B (read/write). Any address with a nonzero bit above bit 3 is unmapped.
- R2: PREADY is high in every cycle where PSEL and PENABLE are both high. It is low in the setup cycle and while PSEL is low.
- R3: While PRESETn is low, and after it is released, `ctrl_a`, `ctrl_b`, `trig_data` and `trig_pulse` are zero until a write changes them.
- R4: A read access that draws no error returns the addressed value on PRDATA in its access cycle. PRDATA is zero in every other cycle, and a read of the trigger word returns zero.
- R5: In APB4 mode a write updates only bits [8i+7:8i] of the target for each PSTRB[i] that is 1. In APB3 mode every byte lane is written whatever PSTRB holds.
- R6: A write to the trigger word loads `trig_data` under the byte lanes of R5. It raises `trig_pulse` for exactly one cycle, the cycle after the access edge.
- R7: In APB4 mode with the address check enabled, an access to an unmapped address completes with PSLVERR high.
- R8: In APB4 mode with the direction check enabled, a write to the status word completes with PSLVERR high.
- R9: In APB4 mode with the direction check enabled, a read of the trigger word completes with PSLVERR high.
- R10: A write that draws an error changes no register and raises no trigger pulse. A read that draws an error returns zero.
- R11: PSLVERR is low outside the access cycle and always low in APB3 mode. In APB3 mode, writes to the status word or to unmapped addresses have no effect.
- R12: PPROT has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Write byte-lane enables |
| pprot | input | 3 | Protection type (ignored) |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Error response |
| status_in | input | DATA_W | Value returned by the status word |
| ctrl_a | output | DATA_W | Control word A |
| ctrl_b | output | DATA_W | Control word B |
| trig_data | output | DATA_W | Last data written to the trigger word |
| trig_pulse | output | 1 | One-cycle pulse per trigger write |

## Verification
The main function is exercised with random mixes of reads and writes over all four offsets and over unmapped addresses. Each access uses random data, byte strobes and PPROT. A reference model predicts the outcome of every access. The random mix separates correct per-register permission decoding from a decoder that confuses the status and trigger words. It also separates lane-gated writes from whole-word writes. Directed cases use nonzero low address bits, an all-zero strobe, and writes refused by the direction and address checks. An APB3-mode instance on the same bus receives the same stimulus, which shows whether strobes and errors are correctly suppressed in that mode.

// File: rtl/apb_csr_pkg.sv
package apb_csr_pkg;

   typedef enum logic [1:0] {
      SLOT_CTRL_A = 2'd0,
      SLOT_STATUS = 2'd1,
      SLOT_TRIG   = 2'd2,
      SLOT_CTRL_B = 2'd3
   } slot_e;

   typedef struct packed {
      logic  hit;
      logic  can_rd;
      logic  can_wr;
      slot_e slot;
   } dec_t;

   localparam int unsigned SLOT_LSB = 2;
   localparam int unsigned MAP_TOP  = 4;

endpackage

// File: rtl/apb_csr_decode.sv
module apb_csr_decode
   import apb_csr_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] paddr,
   output dec_t              dec
);
   logic [1:0] unused_lsb;
   assign unused_lsb = paddr[1:0];

   always_comb begin
      dec.hit    = (paddr[ADDR_W-1:MAP_TOP] == '0);
      dec.slot   = slot_e'(paddr[MAP_TOP-1:SLOT_LSB]);
      dec.can_rd = (dec.slot != SLOT_TRIG);
      dec.can_wr = (dec.slot != SLOT_STATUS);
   end
endmodule

// File: rtl/apb_csr_lane_mask.sv
module apb_csr_lane_mask #(
   parameter int DATA_W    = 32,
   parameter bit APB4_MODE = 1'b1,
   localparam int STRB_W   = DATA_W / 8
) (
   input  logic [STRB_W-1:0] pstrb,
   output logic [DATA_W-1:0] mask
);
   generate
      if (APB4_MODE) begin : g_strobed
         for (genvar i = 0; i < STRB_W; i++) begin : g_lane
            assign mask[8*i +: 8] = {8{pstrb[i]}};
         end
      end else begin : g_full
         logic unused_strb;
         assign unused_strb = ^pstrb;
         assign mask = '1;
      end
   endgenerate
endmodule

// File: rtl/apb_csr_err.sv
module apb_csr_err
   import apb_csr_pkg::*;
#(
   parameter bit APB4_MODE = 1'b1,
   parameter bit CHK_ADDR  = 1'b1,
   parameter bit CHK_DIR   = 1'b1
) (
   input  logic access,
   input  logic pwrite,
   input  dec_t dec,
   output logic err
);
   generate
      if (APB4_MODE) begin : g_apb4
         logic bad_addr, bad_dir;
         if (CHK_ADDR) begin : g_addr
            assign bad_addr = ~dec.hit;
         end else begin : g_no_addr
            assign bad_addr = 1'b0;
         end
         if (CHK_DIR) begin : g_dir
            assign bad_dir = dec.hit & (pwrite ? ~dec.can_wr : ~dec.can_rd);
         end else begin : g_no_dir
            assign bad_dir = 1'b0;
         end
         assign err = access & (bad_addr | bad_dir);
      end else begin : g_apb3
         logic unused_in;
         assign unused_in = ^{access, pwrite, dec};
         assign err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/apb_csr_field.sv
module apb_csr_field #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= (q & ~mask) | (wdata & mask);
   end
endmodule

// File: rtl/apb_csr_port.sv
module apb_csr_port
   import apb_csr_pkg::*;
#(
   parameter int  ADDR_W    = 12,
   parameter int  DATA_W    = 32,
   parameter bit  APB4_MODE = 1'b1,
   parameter bit  CHK_ADDR  = 1'b1,
   parameter bit  CHK_DIR   = 1'b1,
   localparam int STRB_W    = DATA_W / 8
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [STRB_W-1:0] pstrb,
   input  logic [2:0]        pprot,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [DATA_W-1:0] status_in,
   output logic [DATA_W-1:0] ctrl_a,
   output logic [DATA_W-1:0] ctrl_b,
   output logic [DATA_W-1:0] trig_data,
   output logic              trig_pulse
);
   localparam int NUM_CTRL = 2;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("apb_csr_port: DATA_W must be a positive multiple of 8");
      end
      if (ADDR_W <= MAP_TOP) begin : g_bad_addr
         $error("apb_csr_port: ADDR_W must exceed the mapped window");
      end
   endgenerate

   logic unused_prot;
   assign unused_prot = ^pprot;

   logic              access, err, wr_ok, rd_ok;
   dec_t              dec;
   logic [DATA_W-1:0] lane_mask, rd_val;
   logic [DATA_W-1:0] ctrl_q [NUM_CTRL];

   assign access = psel & penable;

   apb_csr_decode #(.ADDR_W(ADDR_W)) i_decode (
      .paddr (paddr),
      .dec   (dec)
   );

   apb_csr_err #(
      .APB4_MODE (APB4_MODE),
      .CHK_ADDR  (CHK_ADDR),
      .CHK_DIR   (CHK_DIR)
   ) i_err (
      .access (access),
      .pwrite (pwrite),
      .dec    (dec),
      .err    (err)
   );

   apb_csr_lane_mask #(.DATA_W(DATA_W), .APB4_MODE(APB4_MODE)) i_mask (
      .pstrb (pstrb),
      .mask  (lane_mask)
   );

   assign wr_ok = access & pwrite  & dec.hit & dec.can_wr & ~err;
   assign rd_ok = access & ~pwrite & dec.hit & dec.can_rd & ~err;

   generate
      for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
         localparam slot_e MY_SLOT = (g == 0) ? SLOT_CTRL_A : SLOT_CTRL_B;
         apb_csr_field #(.DATA_W(DATA_W)) i_field (
            .clk   (pclk),
            .rst_n (presetn),
            .we    (wr_ok && dec.slot == MY_SLOT),
            .mask  (lane_mask),
            .wdata (pwdata),
            .q     (ctrl_q[g])
         );
      end
   endgenerate

   logic trig_we;
   assign trig_we = wr_ok && dec.slot == SLOT_TRIG;

   apb_csr_field #(.DATA_W(DATA_W)) i_trig (
      .clk   (pclk),
      .rst_n (presetn),
      .we    (trig_we),
      .mask  (lane_mask),
      .wdata (pwdata),
      .q     (trig_data)
   );

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) trig_pulse <= 1'b0;
      else          trig_pulse <= trig_we;
   end

   always_comb begin
      unique case (dec.slot)
         SLOT_CTRL_A: rd_val = ctrl_q[0];
         SLOT_STATUS: rd_val = status_in;
         SLOT_CTRL_B: rd_val = ctrl_q[1];
         default:     rd_val = '0;
      endcase
   end

   assign prdata  = rd_ok ? rd_val : '0;
   assign pready  = access;
   assign pslverr = err;
   assign ctrl_a  = ctrl_q[0];
   assign ctrl_b  = ctrl_q[1];
endmodule

// File: rtl/apb_csr_checker.sv
module apb_csr_checker #(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter bit APB4_MODE = 1'b1,
   parameter bit CHK_DIR   = 1'b1
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [DATA_W-1:0] prdata,
   input logic              pready,
   input logic              pslverr,
   input logic [DATA_W-1:0] status_in,
   input logic [DATA_W-1:0] ctrl_a,
   input logic [DATA_W-1:0] ctrl_b,
   input logic              trig_pulse
);
   logic acc, is_status;
   assign acc       = psel && penable;
   assign is_status = (paddr[ADDR_W-1:2] == 1);

   AST_NO_EARLY_READY: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !penable) |-> !pready);                                    // R2
   AST_IDLE_NO_READY: assert property (@(posedge pclk) disable iff (!presetn)
      !psel |-> !pready);                                                 // R2
   AST_RDATA_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
      !(acc && !pwrite) |-> prdata == '0);                                // R4
   AST_STATUS_READ: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && !pwrite && is_status) |-> prdata == status_in);             // R4
   AST_PULSE_SINGLE: assert property (@(posedge pclk) disable iff (!presetn)
      trig_pulse |=> !trig_pulse);                                        // R6
   AST_RO_WRITE_FLAG: assert property (@(posedge pclk) disable iff (!presetn)
      (APB4_MODE && CHK_DIR && acc && pwrite && is_status) |-> pslverr);  // R8
   AST_ERR_READ_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && !pwrite && pslverr) |-> prdata == '0);                      // R10
   AST_ERR_WRITE_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
      (acc && pwrite && pslverr) |=> ($stable(ctrl_a) && $stable(ctrl_b) && !trig_pulse)); // R10
   AST_ERR_IN_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
      !acc |-> !pslverr);                                                 // R11
   AST_APB3_SILENT: assert property (@(posedge pclk) disable iff (!presetn)
      !APB4_MODE |-> !pslverr);                                           // R11
endmodule

bind apb_csr_port apb_csr_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .APB4_MODE (APB4_MODE),
   .CHK_DIR   (CHK_DIR)
) i_chk (
   .pclk       (pclk),
   .presetn    (presetn),
   .psel       (psel),
   .penable    (penable),
   .pwrite     (pwrite),
   .paddr      (paddr),
   .prdata     (prdata),
   .pready     (pready),
   .pslverr    (pslverr),
   .status_in  (status_in),
   .ctrl_a     (ctrl_a),
   .ctrl_b     (ctrl_b),
   .trig_pulse (trig_pulse)
);

// File: tb/test_apb_csr_port.sv
module test_apb_csr_port;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam int SW = DW / 8;

   logic          pclk = 1'b0;
   logic          presetn = 1'b0;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0, status_in = '0;
   logic [SW-1:0] pstrb = '0;
   logic [2:0]    pprot = '0;

   logic [DW-1:0] prdata, ctrl_a, ctrl_b, trig_data;
   logic          pready, pslverr, trig_pulse;
   logic [DW-1:0] prdata3, ctrl_a3, ctrl_b3, trig_data3;
   logic          pready3, pslverr3, trig_pulse3;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   logic [DW-1:0] m_a, m_b, m_t, m_a3, m_b3, m_t3;

   always #(CLK_PERIOD/2) pclk = ~pclk;

   apb_csr_port #(.ADDR_W(AW), .DATA_W(DW)) i_apb_csr_port (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
      .pprot(pprot), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .status_in(status_in), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
      .trig_data(trig_data), .trig_pulse(trig_pulse)
   );

   apb_csr_port #(.ADDR_W(AW), .DATA_W(DW), .APB4_MODE(1'b0)) i_apb_csr_port_apb3 (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
      .pprot(pprot), .prdata(prdata3), .pready(pready3), .pslverr(pslverr3),
      .status_in(status_in), .ctrl_a(ctrl_a3), .ctrl_b(ctrl_b3),
      .trig_data(trig_data3), .trig_pulse(trig_pulse3)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] lanes(input logic [SW-1:0] s);
      logic [DW-1:0] m;
      for (int i = 0; i < SW; i++) m[8*i +: 8] = {8{s[i]}};
      return m;
   endfunction

   function automatic bit map_hit(input logic [AW-1:0] a);
      return a[AW-1:4] == '0;
   endfunction

   function automatic bit exp_err4(input logic [AW-1:0] a, input bit wr);
      if (!map_hit(a)) return 1'b1;                 // R7
      if (wr && a[3:2] == 2'd1) return 1'b1;        // R8
      if (!wr && a[3:2] == 2'd2) return 1'b1;       // R9
      return 1'b0;
   endfunction

   function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a, input logic [DW-1:0] va,
                                            input logic [DW-1:0] vb);
      if (!map_hit(a)) return '0;
      case (a[3:2])
         2'd0: return va;
         2'd1: return status_in;
         2'd3: return vb;
         default: return '0;
      endcase
   endfunction

   // One complete APB transfer, checking both instances against the model.
   task automatic xfer(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d,
                       input logic [SW-1:0] s, input logic [2:0] p);
      bit            e4, pul4, pul3;
      logic [DW-1:0] m4, nv;
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a;
      pwdata = d; pstrb = s; pprot = p;
      #1;
      chk("R2 setup ready", {31'b0, pready}, 32'd0);
      chk("R6 pulse width", {31'b0, trig_pulse}, 32'd0);
      chk("R11 setup err", {31'b0, pslverr}, 32'd0);
      @(negedge pclk);
      penable = 1'b1;
      #1;
      e4 = exp_err4(a, wr);
      chk("R2 access ready", {31'b0, pready}, 32'd1);
      chk("R7/R8/R9 pslverr", {31'b0, pslverr}, {31'b0, e4});
      chk("R11 apb3 err", {31'b0, pslverr3}, 32'd0);
      if (!wr) begin
         chk("R4/R10 rdata", prdata, e4 ? '0 : exp_rd(a, m_a, m_b));
         chk("R4 apb3 rdata", prdata3, exp_rd(a, m_a3, m_b3));
      end else begin
         chk("R4 write rdata", prdata, '0);
      end
      // model update
      m4 = lanes(s);
      pul4 = wr && !e4 && a[3:2] == 2'd2;
      pul3 = wr && map_hit(a) && a[3:2] == 2'd2;
      if (wr && !e4) begin
         case (a[3:2])
            2'd0: m_a = (m_a & ~m4) | (d & m4);
            2'd2: m_t = (m_t & ~m4) | (d & m4);
            2'd3: m_b = (m_b & ~m4) | (d & m4);
            default: nv = '0;
         endcase
      end
      if (wr && map_hit(a)) begin
         case (a[3:2])
            2'd0: m_a3 = d;
            2'd2: m_t3 = d;
            2'd3: m_b3 = d;
            default: nv = '0;
         endcase
      end
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
      #1;
      chk("R10 err quiet after", {31'b0, pslverr}, 32'd0);
      chk("R6 trig pulse", {31'b0, trig_pulse}, {31'b0, pul4});
      chk("R6 apb3 trig pulse", {31'b0, trig_pulse3}, {31'b0, pul3});
      chk("R5/R10 ctrl_a", ctrl_a, m_a);
      chk("R5/R10 ctrl_b", ctrl_b, m_b);
      chk("R6 trig_data", trig_data, m_t);
      chk("R5/R11 apb3 ctrl_a", ctrl_a3, m_a3);
      chk("R5/R11 apb3 ctrl_b", ctrl_b3, m_b3);
      chk("R5 apb3 trig_data", trig_data3, m_t3);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a;
      int unsigned   sel;
      void'($urandom(32'h5EED_0042));
      m_a = '0; m_b = '0; m_t = '0; m_a3 = '0; m_b3 = '0; m_t3 = '0;
      status_in = 32'hC0DE_0001;
      repeat (3) @(negedge pclk);
      #1;
      chk("R3 reset ctrl_a", ctrl_a, '0);
      chk("R3 reset ctrl_b", ctrl_b, '0);
      chk("R3 reset trig", {trig_data[30:0], trig_pulse}, '0);
      chk("R2 reset ready", {31'b0, pready}, '0);
      @(negedge pclk);
      presetn = 1'b1;
      #1;
      chk("R3 after release", ctrl_a | ctrl_b | trig_data, '0);

      // directed corner cases
      xfer(12'h000, 1'b1, 32'h1122_3344, 4'hF, 3'd0);  // R1 full write
      xfer(12'h003, 1'b0, '0, 4'h0, 3'd7);             // R1 low bits ignored, R12
      xfer(12'h00C, 1'b1, 32'hAABB_CCDD, 4'b0101, 3'd5);// R5 partial lanes
      xfer(12'h00C, 1'b1, 32'hFFFF_FFFF, 4'h0, 3'd0);  // R5 zero strobe
      xfer(12'h00E, 1'b0, '0, 4'h0, 3'd0);             // R4 read ctrl_b
      xfer(12'h004, 1'b1, 32'hDEAD_BEEF, 4'hF, 3'd0);  // R8 write status
      xfer(12'h005, 1'b0, '0, 4'h0, 3'd0);             // R4 status read
      xfer(12'h008, 1'b1, 32'h0F0F_0F0F, 4'hF, 3'd0);  // R6 trigger
      xfer(12'h008, 1'b0, '0, 4'h0, 3'd0);             // R9 read trigger
      xfer(12'h010, 1'b1, 32'h5555_5555, 4'hF, 3'd0);  // R7/R10 unmapped write
      xfer(12'h800, 1'b0, '0, 4'h0, 3'd0);             // R7 unmapped read

      // constrained random mix, PPROT random (R12)
      for (int n = 0; n < 400; n++) begin
         sel = $urandom % 6;
         if (sel < 4) a = AW'(sel * 4);
         else         a = AW'(16 + (($urandom % 1000) * 4));
         status_in = $urandom;
         xfer(a, 1'($urandom), $urandom, 4'($urandom), 3'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule